// File: doc/BRIEF.md
# Speculative Issue Window with Bypass Flags

This block is the scheduling window of a four-wide out-of-order core. Each slot holds one renamed instruction: two source tags, one destination tag, a ready flag and a bypass flag for each source, and an issued flag. In every cycle the window picks up to four slots whose sources are both ready and that have not yet issued. It sends them out on four issue lanes and broadcasts their destination tags back into the window. Any waiting source with a matching tag becomes ready at the next edge, so a dependent can issue in the cycle right after its producer.

A tag match also sets that source's bypass flag for exactly one cycle. A dependent that issues immediately after the wakeup therefore reports on its lane that the operand comes from the forwarding network. A dependent that issues later reports that it does not. Selection takes no account of register-file ports. A later arbitration stage returns a repair request for the group issued in the previous cycle, with a per-lane kill mask. The window then un-issues the killed instructions, squashes the group it would issue in the repair cycle, and withdraws the readiness that the killed producers granted, so that everything affected issues again. A slot is freed only by an explicit completion.

Top module: `iw_window`

## Requirements
- R1: After reset no issue lane is valid, the window reports space, and the offered slot is 0.
- R2: An allocation is accepted only while `alloc_ready` is high, and goes to the lowest-numbered free slot, which `alloc_idx` shows. When all slots are occupied, `alloc_ready` is low and a request is ignored.
- R3: A slot accepted at an edge can issue in the next cycle at the earliest. Up to four ready, unissued slots issue per cycle, lowest index first. Lanes fill from lane 0 in ascending slot order.
- R4: An issued slot does not issue again unless it is killed. A completion for a slot frees it so that it can be allocated again.
- R5: The destination tags of the lanes issued in a cycle make all matching sources ready at the following edge, so a dependent issues in the very next cycle.
- R6: A lane reports bypass = 1 for a source only when that source was woken at the edge just before the issue cycle. It reports 0 when the source was woken earlier or was marked ready at allocation.
- R7: A repair request kills exactly the lanes set in its mask, from the group issued in the previous cycle. Those slots become unissued and issue again once eligible, keeping their own readiness.
- R8: In a repair cycle no lane is valid. The slots that would have issued stay unissued, and their destination tags wake nothing.
- R9: Sources woken by a killed producer lose their readiness, and do not issue again until that producer has reissued.
- R10: An allocation whose source tag matches a tag broadcast in the same cycle enters with that source ready and with its bypass flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Request to insert one instruction |
| alloc_src0 | input | TAG_W | First source tag |
| alloc_src0_rdy | input | 1 | First source already available |
| alloc_src1 | input | TAG_W | Second source tag |
| alloc_src1_rdy | input | 1 | Second source already available |
| alloc_dst | input | TAG_W | Destination tag |
| alloc_ready | output | 1 | A free slot exists |
| alloc_idx | output | IDX_W | Slot the next allocation will take |
| iss_valid | output | ISSUE_W | Lane carries an issued instruction |
| iss_idx | output | ISSUE_W x IDX_W | Slot issued on each lane |
| iss_dst | output | ISSUE_W x TAG_W | Destination tag on each lane |
| iss_byp0 | output | ISSUE_W | First source taken from forwarding |
| iss_byp1 | output | ISSUE_W | Second source taken from forwarding |
| rep_valid | input | 1 | Repair for the group issued last cycle |
| rep_lane_kill | input | ISSUE_W | Lanes of that group to kill |
| done_valid | input | 1 | Completion of a slot |
| done_idx | input | IDX_W | Slot that completed |

## Verification
A wrong ready or issued flag shows up on the lanes within one cycle. A slot either issues in a cycle where it should not, or fails to issue in the cycle after its wakeup, or takes the wrong lane position in a group. A stale bypass flag or an un-withdrawn wakeup after a repair shows up no later than the cycle after the repair, on the bypass bits or as a dependent issuing too soon. The scenarios are arranged so that each such flaw changes a lane in an expected cycle.

// File: rtl/iw_pkg.sv
package iw_pkg;

    typedef struct packed {
        logic rdy;
        logic byp;
    } iw_src_t;

    // Next state of one source operand given a tag wakeup and a kill match.
    function automatic iw_src_t iw_src_next(iw_src_t cur, logic wake, logic kill);
        iw_src_t nxt;
        nxt.rdy = (cur.rdy | wake) & ~kill;
        nxt.byp = wake & ~kill;
        return nxt;
    endfunction

endpackage

// File: rtl/iw_pick.sv
module iw_pick #(
    parameter int N = 16,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    output logic         found,
    output logic [W-1:0] idx,
    output logic [N-1:0] onehot
);
    always_comb begin
        found  = |req;
        onehot = req & (~req + N'(1));
        idx    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/iw_match.sv
module iw_match #(
    parameter int LANES = 4,
    parameter int TAG_W = 7
) (
    input  logic [LANES-1:0]            vld,
    input  logic [LANES-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]            probe,
    output logic                        hit
);
    always_comb begin
        hit = 1'b0;
        for (int l = 0; l < LANES; l++) begin
            if (vld[l] && tags[l] == probe) hit = 1'b1;
        end
    end
endmodule

// File: rtl/iw_window.sv
module iw_window
    import iw_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int ISSUE_W = 4,
    parameter int TAG_W   = 7,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            alloc_valid,
    input  logic [TAG_W-1:0]                alloc_src0,
    input  logic                            alloc_src0_rdy,
    input  logic [TAG_W-1:0]                alloc_src1,
    input  logic                            alloc_src1_rdy,
    input  logic [TAG_W-1:0]                alloc_dst,
    output logic                            alloc_ready,
    output logic [IDX_W-1:0]                alloc_idx,
    output logic [ISSUE_W-1:0]              iss_valid,
    output logic [ISSUE_W-1:0][IDX_W-1:0]   iss_idx,
    output logic [ISSUE_W-1:0][TAG_W-1:0]   iss_dst,
    output logic [ISSUE_W-1:0]              iss_byp0,
    output logic [ISSUE_W-1:0]              iss_byp1,
    input  logic                            rep_valid,
    input  logic [ISSUE_W-1:0]              rep_lane_kill,
    input  logic                            done_valid,
    input  logic [IDX_W-1:0]                done_idx
);

    typedef struct packed {
        logic    [ENTRIES-1:0]             vld;
        logic    [ENTRIES-1:0]             iss;
        iw_src_t [ENTRIES-1:0]             op0;
        iw_src_t [ENTRIES-1:0]             op1;
        logic    [ENTRIES-1:0][TAG_W-1:0]  tag0;
        logic    [ENTRIES-1:0][TAG_W-1:0]  tag1;
        logic    [ENTRIES-1:0][TAG_W-1:0]  dst;
        logic    [ISSUE_W-1:0]             last_vld;
        logic    [ISSUE_W-1:0][IDX_W-1:0]  last_idx;
    } win_st_t;

    win_st_t st_q, st_d;

    // ---------------- select: cascade of lowest-first pickers ----------------
    logic [ENTRIES-1:0]                  cand;
    logic [ISSUE_W-1:0][ENTRIES-1:0]     req_chain;
    logic [ISSUE_W-1:0][ENTRIES-1:0]     lane_oh;
    logic [ISSUE_W-1:0][IDX_W-1:0]       lane_idx;
    logic [ISSUE_W-1:0]                  lane_found;

    assign cand         = st_q.vld & ~st_q.iss & ~'0;
    assign req_chain[0] = cand & rdy_both;

    logic [ENTRIES-1:0] rdy_both;
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            rdy_both[i] = st_q.op0[i].rdy & st_q.op1[i].rdy;
        end
    end

    for (genvar l = 0; l < ISSUE_W; l++) begin : g_lane
        iw_pick #(.N(ENTRIES), .W(IDX_W)) u_pick (
            .req    (req_chain[l]),
            .found  (lane_found[l]),
            .idx    (lane_idx[l]),
            .onehot (lane_oh[l])
        );
        if (l < ISSUE_W - 1) begin : g_next
            assign req_chain[l+1] = req_chain[l] & ~lane_oh[l];
        end
        assign iss_valid[l] = lane_found[l] & ~rep_valid;
        assign iss_idx[l]   = lane_idx[l];
        assign iss_dst[l]   = st_q.dst[lane_idx[l]];
        assign iss_byp0[l]  = iss_valid[l] & st_q.op0[lane_idx[l]].byp;
        assign iss_byp1[l]  = iss_valid[l] & st_q.op1[lane_idx[l]].byp;
    end

    // ---------------- repair: kill tags of the previous group ----------------
    logic [ISSUE_W-1:0]            kill_vld;
    logic [ISSUE_W-1:0][TAG_W-1:0] kill_tag;

    for (genvar l = 0; l < ISSUE_W; l++) begin : g_kill
        assign kill_vld[l] = rep_valid & rep_lane_kill[l] & st_q.last_vld[l];
        assign kill_tag[l] = st_q.dst[st_q.last_idx[l]];
    end

    // ---------------- per-entry tag comparators ----------------
    logic [ENTRIES-1:0] wake0, wake1, kill0, kill1;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        iw_match #(.LANES(ISSUE_W), .TAG_W(TAG_W)) u_w0 (
            .vld(iss_valid), .tags(iss_dst), .probe(st_q.tag0[i]), .hit(wake0[i]));
        iw_match #(.LANES(ISSUE_W), .TAG_W(TAG_W)) u_w1 (
            .vld(iss_valid), .tags(iss_dst), .probe(st_q.tag1[i]), .hit(wake1[i]));
        iw_match #(.LANES(ISSUE_W), .TAG_W(TAG_W)) u_k0 (
            .vld(kill_vld), .tags(kill_tag), .probe(st_q.tag0[i]), .hit(kill0[i]));
        iw_match #(.LANES(ISSUE_W), .TAG_W(TAG_W)) u_k1 (
            .vld(kill_vld), .tags(kill_tag), .probe(st_q.tag1[i]), .hit(kill1[i]));
    end

    // ---------------- allocation ----------------
    logic [ENTRIES-1:0] free_oh;
    logic               alloc_fire;
    logic               awake0, awake1, akill0, akill1;

    iw_pick #(.N(ENTRIES), .W(IDX_W)) u_free (
        .req    (~st_q.vld),
        .found  (alloc_ready),
        .idx    (alloc_idx),
        .onehot (free_oh)
    );

    iw_match #(.LANES(ISSUE_W), .TAG_W(TAG_W)) u_aw0 (
        .vld(iss_valid), .tags(iss_dst), .probe(alloc_src0), .hit(awake0));
    iw_match #(.LANES(ISSUE_W), .TAG_W(TAG_W)) u_aw1 (
        .vld(iss_valid), .tags(iss_dst), .probe(alloc_src1), .hit(awake1));
    iw_match #(.LANES(ISSUE_W), .TAG_W(TAG_W)) u_ak0 (
        .vld(kill_vld), .tags(kill_tag), .probe(alloc_src0), .hit(akill0));
    iw_match #(.LANES(ISSUE_W), .TAG_W(TAG_W)) u_ak1 (
        .vld(kill_vld), .tags(kill_tag), .probe(alloc_src1), .hit(akill1));

    assign alloc_fire = alloc_valid & alloc_ready;

    // ---------------- next state ----------------
    logic [ENTRIES-1:0] sel_mask, kill_mask;

    always_comb begin
        sel_mask  = '0;
        kill_mask = '0;
        for (int l = 0; l < ISSUE_W; l++) begin
            if (iss_valid[l]) sel_mask = sel_mask | lane_oh[l];
            if (kill_vld[l])  kill_mask[st_q.last_idx[l]] = 1'b1;
        end

        st_d = st_q;
        for (int i = 0; i < ENTRIES; i++) begin
            st_d.op0[i] = iw_src_next(st_q.op0[i], wake0[i], kill0[i]);
            st_d.op1[i] = iw_src_next(st_q.op1[i], wake1[i], kill1[i]);
            if (sel_mask[i])  st_d.iss[i] = 1'b1;
            if (kill_mask[i]) st_d.iss[i] = 1'b0;
            if (done_valid && done_idx == IDX_W'(i)) begin
                st_d.vld[i] = 1'b0;
                st_d.iss[i] = 1'b0;
            end
            if (alloc_fire && free_oh[i]) begin
                st_d.vld[i]  = 1'b1;
                st_d.iss[i]  = 1'b0;
                st_d.tag0[i] = alloc_src0;
                st_d.tag1[i] = alloc_src1;
                st_d.dst[i]  = alloc_dst;
                st_d.op0[i]  = iw_src_next('{rdy: alloc_src0_rdy, byp: 1'b0}, awake0, akill0);
                st_d.op1[i]  = iw_src_next('{rdy: alloc_src1_rdy, byp: 1'b0}, awake1, akill1);
            end
        end
        st_d.last_vld = iss_valid;
        st_d.last_idx = lane_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/iw_window_chk.sv
module iw_window_chk #(
    parameter int ENTRIES = 16,
    parameter int ISSUE_W = 4,
    parameter int TAG_W   = 7,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          alloc_valid,
    input logic                          alloc_ready,
    input logic [IDX_W-1:0]              alloc_idx,
    input logic [ISSUE_W-1:0]            iss_valid,
    input logic [ISSUE_W-1:0][IDX_W-1:0] iss_idx,
    input logic [ISSUE_W-1:0]            iss_byp0,
    input logic [ISSUE_W-1:0]            iss_byp1,
    input logic                          rep_valid
);

    // R2: an accepted allocation moves the offered slot on
    a_r2_alloc_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready) |=> (!alloc_ready || alloc_idx != $past(alloc_idx)));

    // R8: nothing leaves during a repair cycle
    a_r8_squash_group: assert property (@(posedge clk) disable iff (!rst_n)
        rep_valid |-> (iss_valid == '0));

    for (genvar l = 0; l < ISSUE_W; l++) begin : g_lane_chk
        // R6: a bypass flag needs a broadcast in the previous cycle
        a_r6_bypass_fresh: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_valid[l] && (iss_byp0[l] || iss_byp1[l])) |-> $past(|iss_valid));

        if (l > 0) begin : g_order
            // R3: lanes are packed from lane 0 in ascending slot order
            a_r3_lane_order: assert property (@(posedge clk) disable iff (!rst_n)
                iss_valid[l] |-> (iss_valid[l-1] && iss_idx[l] > iss_idx[l-1]));
        end

        for (genvar m = 0; m < ISSUE_W; m++) begin : g_pair
            // R4: a slot never issues in two consecutive cycles
            a_r4_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
                iss_valid[m] |=> !(iss_valid[l] && iss_idx[l] == $past(iss_idx[m])));
        end
    end

endmodule

bind iw_window iw_window_chk #(
    .ENTRIES(ENTRIES),
    .ISSUE_W(ISSUE_W),
    .TAG_W  (TAG_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_valid(alloc_valid),
    .alloc_ready(alloc_ready),
    .alloc_idx  (alloc_idx),
    .iss_valid  (iss_valid),
    .iss_idx    (iss_idx),
    .iss_byp0   (iss_byp0),
    .iss_byp1   (iss_byp1),
    .rep_valid  (rep_valid)
);

// File: tb/iw_window_tb_top.sv
module iw_window_tb_top;
    localparam int ENT = 16;
    localparam int IW  = 4;
    localparam int TW  = 7;
    localparam int XW  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic               alloc_valid = 1'b0;
    logic [TW-1:0]      alloc_src0 = '0, alloc_src1 = '0, alloc_dst = '0;
    logic               alloc_src0_rdy = 1'b0, alloc_src1_rdy = 1'b0;
    logic               alloc_ready;
    logic [XW-1:0]      alloc_idx;
    logic [IW-1:0]      iss_valid, iss_byp0, iss_byp1;
    logic [IW-1:0][XW-1:0] iss_idx;
    logic [IW-1:0][TW-1:0] iss_dst;
    logic               rep_valid = 1'b0;
    logic [IW-1:0]      rep_lane_kill = '0;
    logic               done_valid = 1'b0;
    logic [XW-1:0]      done_idx = '0;

    iw_window #(.ENTRIES(ENT), .ISSUE_W(IW), .TAG_W(TW)) dut_i (.*);

    typedef struct {
        logic [IW-1:0]        vld;
        logic [IW-1:0][XW-1:0] idx;
        logic [IW-1:0][TW-1:0] dst;
        logic [IW-1:0]        b0;
        logic [IW-1:0]        b1;
        logic                 ardy;
        logic [XW-1:0]        aidx;
        string                req;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk = 0;
    int   n_bad = 0;

    function automatic logic [4*(XW+TW+2)+3:0] lanes_pack(
        logic [IW-1:0] v, logic [IW-1:0][XW-1:0] ix, logic [IW-1:0][TW-1:0] d,
        logic [IW-1:0] p0, logic [IW-1:0] p1);
        logic [4*(XW+TW+2)+3:0] r;
        r = '0;
        r[3:0] = v;
        for (int l = 0; l < IW; l++) begin
            if (v[l]) r[4 + l*(XW+TW+2) +: (XW+TW+2)] = {ix[l], d[l], p0[l], p1[l]};
        end
        return r;
    endfunction

    // monitor: compare one expected item per cycle
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            logic [4*(XW+TW+2)+3:0] got, want;
            e = sb_q.pop_front();
            got  = lanes_pack(iss_valid, iss_idx, iss_dst, iss_byp0, iss_byp1);
            want = lanes_pack(e.vld, e.idx, e.dst, e.b0, e.b1);
            n_chk++;
            if (got !== want) begin
                n_bad++;
                $display("FAIL %s issue lanes: actual %h expected %h", e.req, got, want);
            end
            n_chk++;
            if (alloc_ready !== e.ardy || (e.ardy && alloc_idx !== e.aidx)) begin
                n_bad++;
                $display("FAIL %s alloc: actual rdy=%0b idx=%0d expected rdy=%0b idx=%0d",
                         e.req, alloc_ready, alloc_idx, e.ardy, e.aidx);
            end
        end
    end

    task automatic next_cycle();
        @(posedge clk);
        #1;
        alloc_valid   = 1'b0;
        rep_valid     = 1'b0;
        rep_lane_kill = '0;
        done_valid    = 1'b0;
    endtask

    task automatic alloc(input int s0, input bit r0, input int s1, input bit r1, input int d);
        alloc_valid    = 1'b1;
        alloc_src0     = TW'(s0);
        alloc_src0_rdy = r0;
        alloc_src1     = TW'(s1);
        alloc_src1_rdy = r1;
        alloc_dst      = TW'(d);
    endtask

    // push n lanes with consecutive slots and destination tags
    task automatic push_n(input string req, input int n, input int base_idx, input int base_dst,
                          input logic [IW-1:0] b0, input logic [IW-1:0] b1,
                          input bit ardy, input int aidx);
        exp_t e;
        e.vld = '0; e.idx = '0; e.dst = '0;
        for (int l = 0; l < n; l++) begin
            e.vld[l] = 1'b1;
            e.idx[l] = XW'(base_idx + l);
            e.dst[l] = TW'(base_dst + l);
        end
        e.b0 = b0; e.b1 = b1; e.ardy = ardy; e.aidx = XW'(aidx); e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic push_none(input string req, input bit ardy, input int aidx);
        push_n(req, 0, 0, 0, '0, '0, ardy, aidx);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        push_none("R1", 1, 0);                        // reset state
        next_cycle(); alloc(1, 1, 2, 1, 10);  push_none("R2", 1, 0);
        next_cycle(); alloc(10, 0, 3, 1, 11); push_n("R3", 1, 0, 10, 4'b0, 4'b0, 1, 1);
        next_cycle(); alloc(11, 0, 11, 0, 12); push_n("R10", 1, 1, 11, 4'b1, 4'b0, 1, 2);
        next_cycle(); push_n("R5", 1, 2, 12, 4'b1, 4'b1, 1, 3);
        for (int k = 0; k < 5; k++) begin
            next_cycle(); alloc(30, 0, 5, 1, 40 + k); push_none("R4", 1, 3 + k);
        end
        next_cycle(); alloc(30, 0, 31, 0, 45); push_none("R5", 1, 8);
        next_cycle(); alloc(1, 1, 2, 1, 30);   push_none("R3", 1, 9);
        next_cycle(); push_n("R3", 1, 9, 30, 4'b0, 4'b0, 1, 10);
        next_cycle(); push_n("R3", 4, 3, 40, 4'b1111, 4'b0, 1, 10);   // width and order
        next_cycle(); push_n("R6", 1, 7, 44, 4'b0, 4'b0, 1, 10);       // late issue, no bypass
        // repair of a single-lane group with a dependent
        next_cycle(); alloc(1, 1, 2, 1, 50);  push_none("R5", 1, 10);
        next_cycle(); alloc(50, 0, 3, 1, 51); push_n("R7", 1, 10, 50, 4'b0, 4'b0, 1, 11);
        next_cycle(); rep_valid = 1'b1; rep_lane_kill = 4'b0001; push_none("R8", 1, 12);
        next_cycle(); push_n("R9", 1, 10, 50, 4'b0, 4'b0, 1, 12);      // producer only
        next_cycle(); push_n("R9", 1, 11, 51, 4'b1, 4'b0, 1, 12);      // dependent after it
        // repair killing lane 1 only
        next_cycle(); alloc(70, 0, 3, 1, 71); push_none("R3", 1, 12);
        next_cycle(); alloc(70, 0, 3, 1, 72); push_none("R3", 1, 13);
        next_cycle(); alloc(1, 1, 2, 1, 70);  push_none("R3", 1, 14);
        next_cycle(); push_n("R5", 1, 14, 70, 4'b0, 4'b0, 1, 15);
        next_cycle(); push_n("R3", 2, 12, 71, 4'b0011, 4'b0, 1, 15);
        next_cycle(); rep_valid = 1'b1; rep_lane_kill = 4'b0010; push_none("R8", 1, 15);
        next_cycle(); push_n("R7", 1, 13, 72, 4'b0, 4'b0, 1, 15);      // only lane 1 reissues
        // completion, refill and full window
        next_cycle(); done_valid = 1'b1; done_idx = 4'd0; alloc(1, 1, 2, 1, 80);
        push_none("R4", 1, 15);
        next_cycle(); alloc(99, 0, 2, 1, 81); push_n("R4", 1, 15, 80, 4'b0, 4'b0, 1, 0);
        next_cycle(); alloc(1, 1, 2, 1, 90);  push_none("R2", 0, 0);   // ignored when full
        next_cycle(); push_none("R2", 0, 0);
        next_cycle(); done_valid = 1'b1; done_idx = 4'd1; push_none("R4", 0, 0);
        next_cycle(); push_none("R4", 1, 1);
        next_cycle();
        repeat (3) @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule